// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This unit chooses which physical frame a page-fault handler should fill next. For every one of its frames it holds an occupied flag and a reference bit. A memory access to a frame, signalled on the reference port, marks that frame as recently used. A frame is handed back to the free pool through the release port.

When a replacement is requested, an unoccupied frame is used if one exists, and no resident page is disturbed. If every frame is occupied, a circular hand walks the frames one per clock. Each frame it passes with its reference bit set loses that bit and keeps its page. The first frame whose bit is already clear becomes the victim. The hand keeps its position from one request to the next, so a page touched since the last pass always survives one more sweep.

The handler raises `req_valid` while the unit is idle, then waits for the one-cycle `done` strobe that carries `victim_idx`. `victim_free` tells it whether the frame was empty or must be evicted first.

Top module: `clock_victim_picker`

## Requirements
- R1: After reset `done` and `busy` are 0, every frame is free, and the hand points at frame 0.
- R2: A cycle with `ref_valid`=1 sets the reference bit of frame `ref_idx` to 1 at that clock edge.
- R3: If some frame is free at the edge that accepts a request, the lowest-numbered free frame is returned with `done`=1 and `victim_free`=1 in the following cycle. That frame becomes occupied, and the hand does not move.
- R4: If no frame is free, the unit becomes busy and examines the frame under the hand at each following edge. A frame whose bit is 1 has its bit cleared and the hand steps to the next frame, wrapping from frame N-1 to frame 0.
- R5: The first examined frame whose bit is 0 is the victim. `done` pulses for one cycle with `victim_idx` equal to that frame and `victim_free`=0, and `busy` returns to 0.
- R6: A chosen frame has its reference bit set to 1. After a sweep the hand rests on the frame after the victim.
- R7: When a reference hits the frame that the hand is clearing in the same cycle, the bit ends at 1.
- R8: With no references during the search, `done` rises at most N+1 edges after the accepting edge. With all bits set, the sweep returns the frame where it started.
- R9: `rel_valid`=1 marks frame `rel_idx` free, so the next request returns it through the R3 path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | A memory reference touched a frame |
| ref_idx | input | IDX_W | Frame touched by the reference |
| rel_valid | input | 1 | Return a frame to the free pool |
| rel_idx | input | IDX_W | Frame being returned |
| req_valid | input | 1 | Replacement request, taken only while idle |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle strobe: victim_idx is valid |
| victim_idx | output | IDX_W | Chosen frame |
| victim_free | output | 1 | 1 if the chosen frame was unoccupied |

## Verification
Two functions can act in the same cycle: a memory reference that sets a bit, and the sweeping hand that clears the same bit. The bench sets every bit, starts a sweep, and then references the first frame under the hand on exactly the edge where that frame is examined. When the reference wins, the hand must go round a second time and return the frame after the start at N+2 edges. If the clear wins, the starting frame comes back at N+1 edges, so the victim number and the latency together show which function won.

// File: rtl/cvp_pkg.sv
package cvp_pkg;
   typedef enum logic [0:0] {
      HAND_IDLE  = 1'b0,
      HAND_SWEEP = 1'b1
   } hand_state_e;
endpackage

// File: rtl/cvp_ref_bits.sv
module cvp_ref_bits #(
   parameter int NUM_FRAMES = 8,
   parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ref_valid,
   input  logic [IDX_W-1:0]      ref_idx,
   input  logic                  clr_en,
   input  logic [IDX_W-1:0]      clr_idx,
   input  logic                  set_en,
   input  logic [IDX_W-1:0]      set_idx,
   output logic [NUM_FRAMES-1:0] bits
);
   // Per-frame reference bit: a set (from a reference or an allocation) beats a clear.
   for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_bit
      logic hit_set, hit_clr;
      assign hit_set = (ref_valid && ref_idx == IDX_W'(g)) || (set_en && set_idx == IDX_W'(g));
      assign hit_clr = clr_en && clr_idx == IDX_W'(g);
      always_ff @(posedge clk) begin
         if (!rst_n)       bits[g] <= 1'b0;
         else if (hit_set) bits[g] <= 1'b1;
         else if (hit_clr) bits[g] <= 1'b0;
      end
   end

   AST_REF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      ref_valid |=> bits[$past(ref_idx)]) else $error("reference did not set bit"); // R2
   AST_SWEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !(ref_valid && ref_idx == clr_idx) && !(set_en && set_idx == clr_idx))
      |=> !bits[$past(clr_idx)]) else $error("sweep did not clear bit"); // R4
   AST_REF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && ref_valid && ref_idx == clr_idx) |=> bits[$past(clr_idx)])
      else $error("clear beat a reference"); // R7
endmodule

// File: rtl/cvp_occ_flags.sv
module cvp_occ_flags #(
   parameter int NUM_FRAMES = 8,
   parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rel_valid,
   input  logic [IDX_W-1:0]      rel_idx,
   input  logic                  take_en,
   input  logic [IDX_W-1:0]      take_idx,
   output logic [NUM_FRAMES-1:0] occ,
   output logic                  any_free,
   output logic [IDX_W-1:0]      free_idx
);
   for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_occ
      always_ff @(posedge clk) begin
         if (!rst_n)                                   occ[g] <= 1'b0;
         else if (take_en && take_idx == IDX_W'(g))    occ[g] <= 1'b1;
         else if (rel_valid && rel_idx == IDX_W'(g))   occ[g] <= 1'b0;
      end
   end

   // Lowest-index free frame.
   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = NUM_FRAMES - 1; i >= 0; i--) begin
         if (!occ[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   AST_TAKE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      take_en |-> !occ[take_idx]) else $error("allocated an occupied frame"); // R3
   AST_REL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_valid && !(take_en && take_idx == rel_idx)) |=> !occ[$past(rel_idx)])
      else $error("release ignored"); // R9
endmodule

// File: rtl/cvp_hand.sv
module cvp_hand
   import cvp_pkg::*;
#(
   parameter int NUM_FRAMES = 8,
   parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  any_free,
   input  logic [IDX_W-1:0]      free_idx,
   input  logic [NUM_FRAMES-1:0] bits,
   output logic                  busy,
   output logic                  done,
   output logic [IDX_W-1:0]      victim_idx,
   output logic                  victim_free,
   output logic                  clr_en,
   output logic [IDX_W-1:0]      clr_idx,
   output logic                  set_en,
   output logic [IDX_W-1:0]      set_idx,
   output logic                  take_en,
   output logic [IDX_W-1:0]      take_idx
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FRAMES - 1);

   hand_state_e      state;
   logic [IDX_W-1:0] hand;
   logic [IDX_W-1:0] hand_nxt;
   logic             accept, sweeping, found;

   assign accept   = req_valid && state == HAND_IDLE;
   assign sweeping = state == HAND_SWEEP;
   assign found    = sweeping && !bits[hand];
   assign hand_nxt = (hand == LAST_IDX) ? '0 : hand + 1'b1;

   assign take_en  = accept && any_free;
   assign take_idx = free_idx;
   assign clr_en   = sweeping && bits[hand];
   assign clr_idx  = hand;
   assign set_en   = take_en || found;
   assign set_idx  = take_en ? free_idx : hand;
   assign busy     = sweeping;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= HAND_IDLE;
         hand        <= '0;
         done        <= 1'b0;
         victim_idx  <= '0;
         victim_free <= 1'b0;
      end else begin
         done <= take_en || found;
         if (take_en) begin
            victim_idx  <= free_idx;
            victim_free <= 1'b1;
         end else if (found) begin
            victim_idx  <= hand;
            victim_free <= 1'b0;
         end
         if (accept && !any_free) state <= HAND_SWEEP;
         else if (found)          state <= HAND_IDLE;
         if (sweeping) hand <= hand_nxt;
      end
   end

   AST_FREE_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && any_free) |=> (done && victim_free)) else $error("free path slow"); // R3
   AST_FREE_HOLDS_HAND: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && any_free) |=> $stable(hand)) else $error("hand moved on free path"); // R3
   AST_FOUND_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      found |=> (!busy && done && !victim_free)) else $error("sweep did not end"); // R5
endmodule

// File: rtl/clock_victim_picker.sv
module clock_victim_picker #(
   parameter int NUM_FRAMES = 8,
   parameter int IDX_W      = $clog2(NUM_FRAMES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_valid,
   input  logic [IDX_W-1:0] ref_idx,
   input  logic             rel_valid,
   input  logic [IDX_W-1:0] rel_idx,
   input  logic             req_valid,
   output logic             busy,
   output logic             done,
   output logic [IDX_W-1:0] victim_idx,
   output logic             victim_free
);
   if (NUM_FRAMES < 2) begin : g_bad_frames
      $error("NUM_FRAMES must be at least 2");
   end
   if (IDX_W < $clog2(NUM_FRAMES)) begin : g_bad_width
      $error("IDX_W too narrow for NUM_FRAMES");
   end

   logic [NUM_FRAMES-1:0] bits, occ;
   logic                  any_free;
   logic [IDX_W-1:0]      free_idx;
   logic                  clr_en, set_en, take_en;
   logic [IDX_W-1:0]      clr_idx, set_idx, take_idx;

   cvp_ref_bits #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_bits (
      .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_idx(ref_idx),
      .clr_en(clr_en), .clr_idx(clr_idx), .set_en(set_en), .set_idx(set_idx),
      .bits(bits));

   cvp_occ_flags #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_occ (
      .clk(clk), .rst_n(rst_n), .rel_valid(rel_valid), .rel_idx(rel_idx),
      .take_en(take_en), .take_idx(take_idx), .occ(occ),
      .any_free(any_free), .free_idx(free_idx));

   cvp_hand #(.NUM_FRAMES(NUM_FRAMES), .IDX_W(IDX_W)) u_hand (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .any_free(any_free),
      .free_idx(free_idx), .bits(bits), .busy(busy), .done(done),
      .victim_idx(victim_idx), .victim_free(victim_free),
      .clr_en(clr_en), .clr_idx(clr_idx), .set_en(set_en), .set_idx(set_idx),
      .take_en(take_en), .take_idx(take_idx));

   AST_VICTIM_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (bits[victim_idx] && occ[victim_idx])) else $error("victim not marked"); // R6
endmodule

// File: tb/clock_victim_picker_test.sv
`timescale 1ns/1ps
module clock_victim_picker_test;
   localparam int N  = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_valid = 1'b0, rel_valid = 1'b0, req_valid = 1'b0;
   logic [IW-1:0] ref_idx = '0, rel_idx = '0;
   logic          busy, done, victim_free;
   logic [IW-1:0] victim_idx;

   int tests = 0;
   int fails = 0;

   always #4 clk = ~clk;

   clock_victim_picker #(.NUM_FRAMES(N), .IDX_W(IW)) uut (
      .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_idx(ref_idx),
      .rel_valid(rel_valid), .rel_idx(rel_idx), .req_valid(req_valid),
      .busy(busy), .done(done), .victim_idx(victim_idx), .victim_free(victim_free));

   task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic touch(input int f);
      @(negedge clk); ref_valid = 1'b1; ref_idx = IW'(f);
      @(negedge clk); ref_valid = 1'b0;
   endtask

   task automatic release_frame(input int f);
      @(negedge clk); rel_valid = 1'b1; rel_idx = IW'(f);
      @(negedge clk); rel_valid = 1'b0;
   endtask

   // Latency = edges after the accepting edge until done is seen high.
   task automatic request(input int exp_v, input int exp_lat, input bit exp_free,
                          input bit inj, input int inj_idx, input string rq);
      int lat;
      @(negedge clk); req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk); req_valid = 1'b0;
      if (inj) begin ref_valid = 1'b1; ref_idx = IW'(inj_idx); end
      lat = 0;
      while (!done && lat < 40) begin
         @(posedge clk); lat++;
         @(negedge clk); ref_valid = 1'b0;
      end
      chk(done == 1'b1, rq, "done strobe", int'(done), 1);
      chk(int'(victim_idx) == exp_v, rq, "victim index", int'(victim_idx), exp_v);
      chk(victim_free == exp_free, rq, "victim_free", int'(victim_free), int'(exp_free));
      chk(lat == exp_lat, rq, "latency", lat, exp_lat);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, rq, "done one cycle, idle", int'({busy, done}), 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R1", "reset done", int'(done), 0);
      chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
      rst_n = 1'b1;

      // R1/R3: all free after reset, handed out lowest index first, 0..N-1.
      for (int f = 0; f < N; f++) request(f, 0, 1'b1, 1'b0, 0, "R3");

      // R4/R8: all bits set, hand at 0: full sweep then frame 0 at N+1 edges.
      request(0, N + 1, 1'b0, 1'b0, 0, "R8");
      // R5/R6: hand now at 1, bit 1 clear: immediate hit.
      request(1, 1, 1'b0, 1'b0, 0, "R6");
      // R2/R4: references to 2 and 3 force two clears, victim 4.
      touch(2); touch(3);
      request(4, 3, 1'b0, 1'b0, 0, "R2");
      // R7: all bits set, hand at 5; reference to 5 on its examine edge.
      for (int f = 0; f < N; f++) touch(f);
      request(6, N + 2, 1'b0, 1'b1, 5, "R7");
      // R9/R3: released frames come back through the free path, lowest first.
      release_frame(6); release_frame(3);
      request(3, 0, 1'b1, 1'b0, 0, "R9");
      request(6, 0, 1'b1, 1'b0, 0, "R9");
      // R3/R6: hand was left at 7 by the free path; bit 7 clear.
      request(7, 1, 1'b0, 1'b0, 0, "R6");
      // R4: wrap from frame 7 to frame 0, bit 0 clear.
      request(0, 1, 1'b0, 1'b0, 0, "R4");
      // R5: hand at 1 (bit set by earlier touches then cleared), 1 clear.
      request(1, 1, 1'b0, 1'b0, 0, "R5");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule